// File: doc/BRIEF.md
# Halt and Wake Sequencer

This block takes a small processor core into a low-power halt state and brings it back out. A halt strobe from instruction decode is the only way in. On entry the core clock enable drops, the power-down flag is set, the time-out flag is cleared, the watchdog is told to clear, and the pin levels and pending interrupt requests are captured as a reference.

While halted, the block watches four wake sources: external reset, watchdog overflow, an interrupt request that arrived after the halt, and a falling pin edge on an enabled pin. The winner decides a 2-bit resume action. Once a wake is taken, the core clock runs for a fixed startup window. After that window the action is issued as a one-cycle pulse, and interrupt vectoring, watchdog reset or full reset logic elsewhere acts on it.

The controller runs on an always-running reference clock. This is how it sees pin edges while the core clock is gated.

Top module: `pdwake_ctrl`

## Requirements
- R1: A cycle with `halt_i` high while running makes `sys_clk_en_o` low from the next cycle on. It stays low until a wake is taken, and no other input leads into the halted state.
- R2: Halt entry sets `pdf_o` to 1 and `to_o` to 0 in the next cycle.
- R3: After reset, `pdf_o`=0, `to_o`=0, `sys_clk_en_o`=1 and `resume_vld_o`=0. While running, `clr_wdt_i` clears `pdf_o` in the next cycle, and a wake leaves `pdf_o` unchanged.
- R4: `wdt_clr_o` is a one-cycle pulse in the cycle after halt entry. While halted, `wdt_run_o` equals `wdt_own_osc_i`, and an overflow with `wdt_own_osc_i`=0 wakes nothing.
- R5: An external reset while halted gives resume code 3 (full reset).
- R6: A watchdog overflow while halted with `wdt_own_osc_i`=1 gives resume code 2 (watchdog reset) and sets `to_o`.
- R7: A high-to-low change of a pin, measured against its level at halt entry, wakes with code 0 (continue) when that pin is enabled. Bit k of `pa_wake_en_i` enables `pa_i[k]`. Bit k of `pb_nib_en_i` enables `pb_i[4k+3:4k]`.
- R8: An interrupt wake gives code 1 (take vector) when a waking request has its enable set and `stack_full_i` is 0. Otherwise it gives code 0.
- R9: An interrupt request already high at halt entry cannot wake the block.
- R10: After a wake, `sys_clk_en_o` is high for exactly START_CYC cycles. Then `resume_vld_o` pulses for one cycle, with the default START_CYC of 1024.
- R11: Simultaneous sources resolve in this order: external reset, then watchdog, then interrupt, then pin. `to_o` is set only when the watchdog wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-running reference clock |
| rst_ni | input | 1 | active-low asynchronous power-up reset |
| halt_i | input | 1 | halt instruction strobe |
| clr_wdt_i | input | 1 | clear-watchdog instruction strobe |
| wdt_ovf_i | input | 1 | watchdog overflow |
| wdt_own_osc_i | input | 1 | 1: watchdog runs from its own oscillator |
| ext_rst_i | input | 1 | external reset request |
| pa_i | input | PA_W | first port pin levels |
| pa_wake_en_i | input | PA_W | per-pin wake enables, first port |
| pb_i | input | PB_W | other port pin levels |
| pb_nib_en_i | input | PB_W/4 | per-nibble wake enables, other port |
| irq_req_i | input | IRQ_N | interrupt request flags |
| irq_en_i | input | IRQ_N | interrupt enables |
| stack_full_i | input | 1 | call stack full |
| sys_clk_en_o | output | 1 | core clock enable |
| wdt_clr_o | output | 1 | watchdog clear pulse at halt entry |
| wdt_run_o | output | 1 | watchdog allowed to count |
| pdf_o | output | 1 | power-down flag |
| to_o | output | 1 | watchdog time-out flag |
| resume_vld_o | output | 1 | resume action strobe |
| resume_code_o | output | 2 | 0 continue, 1 vector, 2 watchdog reset, 3 full reset |

## Verification
The functions that can share a cycle are the wake sources themselves. External reset, watchdog overflow, a fresh interrupt and a pin edge are all checked in the same halted cycle. The bench provokes this by driving two or three of them on one edge. It judges the result by the resume code and the time-out flag after the startup window, which must match the winner that the fixed priority names. A second overlap is a pending interrupt together with a pin edge. Here the bench checks that the stale request stays silent and the pin alone wins.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;
  typedef enum logic [1:0] {
    RES_CONT = 2'd0,
    RES_VEC  = 2'd1,
    RES_WDT  = 2'd2,
    RES_FULL = 2'd3
  } res_code_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WARM = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pdwake_pin_det.sv
module pdwake_pin_det #(
  parameter int PA_W = 8,
  parameter int PB_W = 8,
  localparam int NIB = PB_W / 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            snap_i,
  input  logic [PA_W-1:0] pa_i,
  input  logic [PA_W-1:0] pa_en_i,
  input  logic [PB_W-1:0] pb_i,
  input  logic [NIB-1:0]  pb_nib_en_i,
  output logic            wake_o
);
  logic [PA_W-1:0] pa_ref_q;
  logic [PB_W-1:0] pb_ref_q;
  logic [PB_W-1:0] pb_en;

  for (genvar g = 0; g < PB_W; g++) begin : g_nib
    assign pb_en[g] = pb_nib_en_i[g/4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_ref_q <= '0;
      pb_ref_q <= '0;
    end else if (snap_i) begin
      pa_ref_q <= pa_i;
      pb_ref_q <= pb_i;
    end
  end

  assign wake_o = |(pa_ref_q & ~pa_i & pa_en_i) | |(pb_ref_q & ~pb_i & pb_en);

  // R7: no enabled pin, no pin wake
  a_r7_no_wake_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_en_i == '0 && pb_nib_en_i == '0) |-> !wake_o);
endmodule

// File: rtl/pdwake_src_arb.sv
module pdwake_src_arb
  import pdwake_pkg::*;
#(
  parameter int IRQ_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_i,
  input  logic             ext_i,
  input  logic             wdt_i,
  input  logic [IRQ_N-1:0] irq_req_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  input  logic             stack_full_i,
  input  logic             pin_i,
  output logic             wake_o,
  output logic             wdt_win_o,
  output res_code_e        code_o
);
  logic [IRQ_N-1:0] arm_q;
  logic [IRQ_N-1:0] irq_wake;

  // requests already pending at halt lose wake ability
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= '0;
    else if (snap_i) arm_q <= ~irq_req_i;
  end

  assign irq_wake = irq_req_i & arm_q;

  always_comb begin
    wake_o    = 1'b1;
    wdt_win_o = 1'b0;
    if (ext_i) begin
      code_o = RES_FULL;
    end else if (wdt_i) begin
      code_o    = RES_WDT;
      wdt_win_o = 1'b1;
    end else if (|irq_wake) begin
      code_o = (|(irq_wake & irq_en_i) && !stack_full_i) ? RES_VEC : RES_CONT;
    end else begin
      code_o = RES_CONT;
      wake_o = pin_i;
    end
  end

  // R11: external reset always wins
  a_r11_ext_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_i |-> (code_o == RES_FULL && wake_o));
  // R8: a full stack never yields a vector
  a_r8_no_vec_stack_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> code_o != RES_VEC);
endmodule

// File: rtl/pdwake_startup.sv
module pdwake_startup #(
  parameter int START_CYC = 1024,
  localparam int CW = (START_CYC > 1) ? $clog2(START_CYC) : 1,
  localparam logic [CW-1:0] LAST = CW'(START_CYC - 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = act_q && (cnt_q == LAST);

  // R10: count never passes the window
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r10_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !act_q);
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdwake_pkg::*;
#(
  parameter int PA_W      = 8,
  parameter int PB_W      = 8,
  parameter int IRQ_N     = 4,
  parameter int START_CYC = 1024,
  localparam int NIB = PB_W / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             clr_wdt_i,
  input  logic             wdt_ovf_i,
  input  logic             wdt_own_osc_i,
  input  logic             ext_rst_i,
  input  logic [PA_W-1:0]  pa_i,
  input  logic [PA_W-1:0]  pa_wake_en_i,
  input  logic [PB_W-1:0]  pb_i,
  input  logic [NIB-1:0]   pb_nib_en_i,
  input  logic [IRQ_N-1:0] irq_req_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  input  logic             stack_full_i,
  output logic             sys_clk_en_o,
  output logic             wdt_clr_o,
  output logic             wdt_run_o,
  output logic             pdf_o,
  output logic             to_o,
  output logic             resume_vld_o,
  output logic [1:0]       resume_code_o
);
  pd_state_e state_q;
  res_code_e code_q, arb_code;
  logic      enter, pin_wake, wake, wdt_win, warm_done, take;

  assign enter = (state_q == ST_RUN) && halt_i;

  pdwake_pin_det #(.PA_W(PA_W), .PB_W(PB_W)) i_pin (
    .clk_i, .rst_ni,
    .snap_i      (enter),
    .pa_i, .pa_en_i(pa_wake_en_i),
    .pb_i, .pb_nib_en_i,
    .wake_o      (pin_wake)
  );

  pdwake_src_arb #(.IRQ_N(IRQ_N)) i_arb (
    .clk_i, .rst_ni,
    .snap_i      (enter),
    .ext_i       (ext_rst_i),
    .wdt_i       (wdt_ovf_i && wdt_own_osc_i),
    .irq_req_i, .irq_en_i, .stack_full_i,
    .pin_i       (pin_wake),
    .wake_o      (wake),
    .wdt_win_o   (wdt_win),
    .code_o      (arb_code)
  );

  assign take = (state_q == ST_HALT) && wake;

  pdwake_startup #(.START_CYC(START_CYC)) i_start (
    .clk_i, .rst_ni,
    .start_i (take),
    .done_o  (warm_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      code_q       <= RES_CONT;
      pdf_o        <= 1'b0;
      to_o         <= 1'b0;
      wdt_clr_o    <= 1'b0;
      resume_vld_o <= 1'b0;
    end else begin
      wdt_clr_o    <= enter;
      resume_vld_o <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (enter) begin
            state_q <= ST_HALT;
            pdf_o   <= 1'b1;
            to_o    <= 1'b0;
          end else if (clr_wdt_i) begin
            pdf_o <= 1'b0;
          end
        end
        ST_HALT: begin
          if (take) begin
            state_q <= ST_WARM;
            code_q  <= arb_code;
            if (wdt_win) to_o <= 1'b1;
          end
        end
        ST_WARM: begin
          if (warm_done) begin
            state_q      <= ST_RUN;
            resume_vld_o <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign sys_clk_en_o  = (state_q != ST_HALT);
  assign wdt_run_o     = (state_q != ST_HALT) || wdt_own_osc_i;
  assign resume_code_o = code_q;

  // R1: halt entry gates the clock next cycle
  a_r1_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> !sys_clk_en_o);
  // R2: flags at entry
  a_r2_entry_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> (pdf_o && !to_o));
  // R4: clear pulse is single and falls in the halted cycle
  a_r4_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |-> (!sys_clk_en_o && $past(enter)));
  // R10: resume strobe lasts one cycle
  a_r10_resume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_vld_o |=> !resume_vld_o);
  // R6: watchdog resume implies time-out flag
  a_r6_to_with_wdt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_vld_o && resume_code_o == RES_WDT) |-> to_o);
  // R3: a wake never changes the power-down flag
  a_r3_pdf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> pdf_o);
endmodule

// File: tb/test_pdwake_ctrl.sv
module test_pdwake_ctrl;
  localparam int PA_W = 8, PB_W = 8, IRQ_N = 4, START_CYC = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 0, clr_wdt = 0, wdt_ovf = 0, own_osc = 0, ext_rst = 0, stack_full = 0;
  logic [PA_W-1:0] pa = '1, pa_en = '0;
  logic [PB_W-1:0] pb = '1;
  logic [1:0] pb_en = '0;
  logic [IRQ_N-1:0] irq_req = '0, irq_en = '0;
  logic sys_clk_en, wdt_clr, wdt_run, pdf, to_f, res_vld;
  logic [1:0] res_code;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pdwake_ctrl #(.PA_W(PA_W), .PB_W(PB_W), .IRQ_N(IRQ_N), .START_CYC(START_CYC)) i_pdwake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .clr_wdt_i(clr_wdt),
    .wdt_ovf_i(wdt_ovf), .wdt_own_osc_i(own_osc), .ext_rst_i(ext_rst),
    .pa_i(pa), .pa_wake_en_i(pa_en), .pb_i(pb), .pb_nib_en_i(pb_en),
    .irq_req_i(irq_req), .irq_en_i(irq_en), .stack_full_i(stack_full),
    .sys_clk_en_o(sys_clk_en), .wdt_clr_o(wdt_clr), .wdt_run_o(wdt_run),
    .pdf_o(pdf), .to_o(to_f), .resume_vld_o(res_vld), .resume_code_o(res_code)
  );

  typedef struct packed {
    logic [7:0] pa_fall;
    logic [7:0] pb_fall;
    logic [7:0] pa_en;
    logic [1:0] pb_en;
    logic [3:0] irq;
    logic [3:0] irq_en;
    logic       sf;
    logic       wdt;
    logic       ext;
    logic       own;
    logic [1:0] code;
    logic       to;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h01, 8'h00, 8'h01, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R7 port A
    '{8'h00, 8'h20, 8'h00, 2'b10, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R7 nibble 1
    '{8'h00, 8'h00, 8'h00, 2'b00, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0}, // R8 vector
    '{8'h00, 8'h00, 8'h00, 2'b00, 4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 disabled
    '{8'h00, 8'h00, 8'h00, 2'b00, 4'h4, 4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 stack full
    '{8'h00, 8'h00, 8'h00, 2'b00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1}, // R6
    '{8'h00, 8'h00, 8'h00, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0}, // R5
    '{8'h80, 8'h00, 8'h80, 2'b00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0}, // R11 ext+wdt+pin
    '{8'h00, 8'h00, 8'h00, 2'b00, 4'h8, 4'h8, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1}, // R11 wdt+irq
    '{8'h02, 8'h00, 8'h02, 2'b00, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0}  // R11 irq+pin
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enter_halt();
    @(negedge clk); halt = 1;
    @(negedge clk); halt = 0;
  endtask

  // counts enabled cycles up to the resume strobe
  task automatic run_to_resume(output int n);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      if (res_vld) break;
      if (sys_clk_en) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R3 reset clk_en", sys_clk_en, 1);
    chk("R3 reset pdf", pdf, 0);
    chk("R3 reset to", to_f, 0);
    chk("R3 reset vld", res_vld, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[v]) begin
      pa_en = VEC[v].pa_en; pb_en = VEC[v].pb_en; irq_en = VEC[v].irq_en;
      stack_full = VEC[v].sf; own_osc = VEC[v].own;
      irq_req = '0; pa = '1; pb = '1;
      enter_halt();
      chk("R1 asleep", sys_clk_en, 0);
      chk("R2 pdf set", pdf, 1);
      chk("R2 to clear", to_f, 0);
      pa = ~VEC[v].pa_fall; pb = ~VEC[v].pb_fall; irq_req = VEC[v].irq;
      wdt_ovf = VEC[v].wdt; ext_rst = VEC[v].ext;
      @(negedge clk);
      wdt_ovf = 0; ext_rst = 0;
      run_to_resume(n);
      chk("R10 window", n, START_CYC);
      chk("R10 strobe", res_vld, 1);
      chk($sformatf("R11 code row %0d", v), res_code, VEC[v].code);
      chk($sformatf("R6 to row %0d", v), to_f, VEC[v].to);
      chk("R3 pdf kept", pdf, 1);
      @(negedge clk);
      chk("R10 single", res_vld, 0);
    end

    // R3: clr_wdt clears pdf
    @(negedge clk); clr_wdt = 1;
    @(negedge clk); clr_wdt = 0;
    chk("R3 clr pdf", pdf, 0);

    // R4: clear pulse, stopped watchdog ignored
    irq_req = '0; pa = '1; pb = '1; pa_en = '0; pb_en = '0; own_osc = 0;
    @(negedge clk); halt = 1;
    @(negedge clk); halt = 0;
    chk("R4 clr pulse", wdt_clr, 1);
    chk("R4 run off", wdt_run, 0);
    @(negedge clk);
    chk("R4 clr single", wdt_clr, 0);
    wdt_ovf = 1;
    repeat (4) @(negedge clk);
    wdt_ovf = 0;
    chk("R4 ovf ignored", sys_clk_en, 0);
    // R7: disabled pin edge ignored
    pa = 8'h00; pb = 8'h00;
    repeat (4) @(negedge clk);
    chk("R7 disabled pin", sys_clk_en, 0);
    own_osc = 1;
    @(negedge clk);
    chk("R4 run own osc", wdt_run, 1);
    ext_rst = 1;
    @(negedge clk); ext_rst = 0;
    run_to_resume(n);
    chk("R5 code", res_code, 3);
    chk("R6 to stays", to_f, 0);

    // R9: stale request cannot wake, pin still can
    pa = '1; pb = '1; pa_en = 8'h10; irq_en = '1; stack_full = 0;
    irq_req = 4'h2;
    @(negedge clk);
    enter_halt();
    repeat (5) @(negedge clk);
    chk("R9 stale irq", sys_clk_en, 0);
    pa = 8'hEF;
    @(negedge clk);
    run_to_resume(n);
    chk("R9 pin wins", res_code, 0);
    chk("R10 window", n, START_CYC);

    // R1: no halt, no sleep
    irq_req = '0;
    repeat (10) @(negedge clk);
    chk("R1 stays running", sys_clk_en, 1);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule